// File: doc/BRIEF.md
# Prefetch Request Duplicate Filter with Degree Expansion

This block sits between a pattern predictor and the cache fill path. The predictor hands it a candidate block address and a signed step, counted in 64-byte blocks. The filter expands that candidate into up to `DEGREE` addresses. It starts from the candidate and adds the step once per further address. Any address that falls outside the 4 KB page of the candidate ends the expansion.

Each generated address is compared in parallel against a FIFO history of recent block addresses. A match means the address is a duplicate, so it is skipped and the expansion moves on to the next step. An address that passes is presented as a request on a ready/valid port and is written into the history in the same cycle.

Demand accesses that hit previously prefetched lines are also reported to the block and written into the same history. The history therefore follows the miss stream that would have occurred without prefetching, and later candidates are filtered against that stream. Each request carries a fill-level bit. It selects the second-level cache normally, and the last-level cache when the second-level miss-handling registers are reported full.

Top module: `pf_hist_filter`

## Requirements
- R1: After reset, `reqValid` is 0, `candReady` is 1 and the history holds no valid entry, so the first candidate is never suppressed.
- R2: A candidate is taken only in a cycle where `candValid` and `candReady` are both 1. `candReady` is 0 while an expansion is in progress and while a request is waiting with `reqReady` low.
- R3: For step i (0 to DEGREE-1), the generated address is the candidate's block plus i times `candDelta`. `candDelta` is an 8-bit two's-complement count of 64-byte blocks. Requests come out in increasing i, with `reqAddr[5:0]` equal to 0.
- R4: A generated address whose bits [63:6] equal those of any valid history entry is not issued. The expansion still continues with the next step.
- R5: Every issued request address is written into the history when it is formed, so later steps and candidates see it.
- R6: A pulse of `hitValid` writes `hitAddr` into the history, and later generated addresses in the same block are suppressed.
- R7: The history keeps `DEPTH` entries (default 32) and overwrites its oldest entry when full. After `DEPTH` newer writes, an address is no longer suppressed.
- R8: When a generated address has bits [63:12] different from those of the candidate, nothing is issued for that step or any later step of the same candidate.
- R9: `reqFillLlc` is 0 (fill second-level cache) when `mshrFull` was 0 in the cycle the request was formed, and 1 (fill last-level cache) when it was 1.
- R10: While `reqValid` is 1 and `reqReady` is 0, `reqValid`, `reqAddr` and `reqFillLlc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | Candidate present |
| candReady | output | 1 | Candidate can be taken this cycle |
| candAddr | input | 64 | Predicted address |
| candDelta | input | 8 | Signed step in blocks |
| hitValid | input | 1 | Demand hit on a prefetched line |
| hitAddr | input | 64 | Address of that demand hit |
| mshrFull | input | 1 | Second-level miss registers full |
| reqValid | output | 1 | Prefetch request valid |
| reqReady | input | 1 | Request accepted downstream |
| reqAddr | output | 64 | Block-aligned request address |
| reqFillLlc | output | 1 | 1 = fill last-level cache, 0 = second level |

## Verification
The assertions assume the consumer of the request port follows ready/valid rules, and that a hit report and an issued request written in the same cycle land in consecutive history slots. The stall-hold and fill-level properties take `mshrFull` as sampled only in the cycle a request is formed. The bench therefore holds `mshrFull` steady for a whole candidate, and it reports hits only while no expansion is running, so its reference history sees writes in the same order as the design. Candidate addresses come from a handful of pages with small steps. This makes duplicates and page crossings frequent while the random readiness keeps the stall path busy.

// File: rtl/pf_hist_pkg.sv
`timescale 1ns/1ps
package pf_hist_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic loadBase;  // capture a new candidate
    logic advance;   // step the generator by one delta
    logic issue;     // form a request and write it into the history
  } pfhStrobe_t;
endpackage

// File: rtl/pf_hist_dp.sv
`timescale 1ns/1ps
module pf_hist_dp
  import pf_hist_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DEPTH    = 32,
  parameter int DELTA_W  = 8,
  parameter int BLK_LSB  = 6,
  parameter int PAGE_LSB = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pfhStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   candAddr,
  input  logic [DELTA_W-1:0]  candDelta,
  input  logic                hitValid,
  input  logic [ADDR_W-1:0]   hitAddr,
  input  logic                mshrFull,
  input  logic                reqReady,
  output logic                dupHit,
  output logic                pageCross,
  output logic                outValid,
  output logic [ADDR_W-1:0]   outAddr,
  output logic                outFill
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BLK_W  = ADDR_W - BLK_LSB;
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic [ADDR_W-1:0]  histAddr [DEPTH];
  logic [DEPTH-1:0]   histVld;
  logic [DEPTH-1:0]   matchVec;
  logic [PTR_W-1:0]   wrPtr, hitPtr, nextPtr;
  logic [BLK_W-1:0]   curBlk;
  logic [PAGE_W-1:0]  basePage;
  logic [DELTA_W-1:0] deltaReg;
  logic [ADDR_W-1:0]  curAddr;
  logic [BLK_W-1:0]   stepExt;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign curAddr   = {curBlk, {BLK_LSB{1'b0}}};
  assign stepExt   = {{(BLK_W - DELTA_W){deltaReg[DELTA_W-1]}}, deltaReg};
  assign pageCross = (curAddr[ADDR_W-1:PAGE_LSB] != basePage);

  // parallel compare against every history slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign matchVec[g] = histVld[g] && (histAddr[g][ADDR_W-1:BLK_LSB] == curBlk);
  end
  assign dupHit = |matchVec;

  // issued address takes the write slot first, a hit report the one after
  assign hitPtr  = strobe.issue ? ptrInc(wrPtr) : wrPtr;
  assign nextPtr = hitValid ? ptrInc(hitPtr) : hitPtr;

  always_ff @(posedge clk) begin
    if (strobe.issue) histAddr[wrPtr]  <= curAddr;
    if (hitValid)     histAddr[hitPtr] <= hitAddr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      histVld <= '0;
      wrPtr   <= '0;
    end else begin
      if (strobe.issue) histVld[wrPtr]  <= 1'b1;
      if (hitValid)     histVld[hitPtr] <= 1'b1;
      wrPtr <= nextPtr;
    end
  end

  // address generator
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curBlk   <= '0;
      basePage <= '0;
      deltaReg <= '0;
    end else if (strobe.loadBase) begin
      curBlk   <= candAddr[ADDR_W-1:BLK_LSB];
      basePage <= candAddr[ADDR_W-1:PAGE_LSB];
      deltaReg <= candDelta;
    end else if (strobe.advance) begin
      curBlk <= curBlk + stepExt;
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outFill  <= 1'b0;
    end else if (strobe.issue) begin
      outValid <= 1'b1;
      outAddr  <= curAddr;
      outFill  <= mshrFull;
    end else if (reqReady) begin
      outValid <= 1'b0;
    end
  end

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !reqReady) |=> (outValid && $stable(outAddr) && $stable(outFill)));

  a_r9_fill_level: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |=> (outFill == $past(mshrFull)));

  a_r4_no_dup_issue: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |-> !dupHit);

  a_r8_no_cross_issue: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |-> !pageCross);

  a_r8_out_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outAddr[ADDR_W-1:PAGE_LSB] == basePage));
endmodule

// File: rtl/pf_hist_ctrl.sv
`timescale 1ns/1ps
module pf_hist_ctrl
  import pf_hist_pkg::*;
#(
  parameter int DEGREE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       candValid,
  input  logic       reqReady,
  input  logic       outValid,
  input  logic       dupHit,
  input  logic       pageCross,
  output logic       candReady,
  output pfhStrobe_t strobe
);
  localparam int STEP_W = (DEGREE > 1) ? $clog2(DEGREE) : 1;

  logic              busy;
  logic [STEP_W-1:0] stepCnt;
  logic              slotFree, go, lastStep;

  always_comb begin
    slotFree        = !outValid || reqReady;
    candReady       = !busy && slotFree;
    go              = busy && slotFree;
    lastStep        = (stepCnt == STEP_W'(DEGREE - 1));
    strobe.loadBase = candValid && candReady;
    strobe.advance  = go && !pageCross;
    strobe.issue    = go && !pageCross && !dupHit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      stepCnt <= '0;
    end else if (strobe.loadBase) begin
      busy    <= 1'b1;
      stepCnt <= '0;
    end else if (go) begin
      if (pageCross || lastStep) busy <= 1'b0;
      stepCnt <= stepCnt + 1'b1;
    end
  end

  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(stepCnt) < DEGREE));

  a_r2_stall_blocks_cand: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !reqReady) |-> !candReady);
endmodule

// File: rtl/pf_hist_filter.sv
`timescale 1ns/1ps
module pf_hist_filter
  import pf_hist_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DEPTH      = 32,
  parameter int DEGREE     = 2,
  parameter int DELTA_W    = 8,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               candValid,
  output logic               candReady,
  input  logic [ADDR_W-1:0]  candAddr,
  input  logic [DELTA_W-1:0] candDelta,
  input  logic               hitValid,
  input  logic [ADDR_W-1:0]  hitAddr,
  input  logic               mshrFull,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic               reqFillLlc
);
  localparam int BLK_LSB  = $clog2(BLK_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);

  pfhStrobe_t strobe;
  logic       dupHit, pageCross;

  pf_hist_ctrl #(.DEGREE(DEGREE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .candValid(candValid), .reqReady(reqReady),
    .outValid(reqValid), .dupHit(dupHit), .pageCross(pageCross),
    .candReady(candReady), .strobe(strobe)
  );

  pf_hist_dp #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .DELTA_W(DELTA_W),
    .BLK_LSB(BLK_LSB), .PAGE_LSB(PAGE_LSB)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .candAddr(candAddr),
    .candDelta(candDelta), .hitValid(hitValid), .hitAddr(hitAddr),
    .mshrFull(mshrFull), .reqReady(reqReady), .dupHit(dupHit),
    .pageCross(pageCross), .outValid(reqValid), .outAddr(reqAddr),
    .outFill(reqFillLlc)
  );

  a_r3_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (reqAddr[BLK_LSB-1:0] == '0));
endmodule

// File: tb/pf_hist_filter_tb.sv
`timescale 1ns/1ps
module pf_hist_filter_tb;
  localparam int DEG = 3;
  localparam int HD  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        candValid = 1'b0;
  logic        candReady;
  logic [63:0] candAddr = '0;
  logic [7:0]  candDelta = '0;
  logic        hitValid = 1'b0;
  logic [63:0] hitAddr = '0;
  logic        mshrFull = 1'b0;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [63:0] reqAddr;
  logic        reqFillLlc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference history, block numbers
  logic [57:0] mHist [HD];
  bit          mVld  [HD];
  int          mPtr = 0;
  logic [57:0] expBlk [DEG];
  int          expN;

  always #2.5 clk = ~clk;

  pf_hist_filter #(.DEGREE(DEG)) u_dut (
    .clk(clk), .rst_n(rst_n), .candValid(candValid), .candReady(candReady),
    .candAddr(candAddr), .candDelta(candDelta), .hitValid(hitValid),
    .hitAddr(hitAddr), .mshrFull(mshrFull), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqFillLlc(reqFillLlc)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit mHas(input logic [57:0] b);
    for (int i = 0; i < HD; i++) if (mVld[i] && mHist[i] == b) return 1;
    return 0;
  endfunction

  function automatic void mPush(input logic [57:0] b);
    mHist[mPtr] = b;
    mVld[mPtr]  = 1;
    mPtr = (mPtr + 1) % HD;
  endfunction

  // R3 R4 R5 R8: expected requests of one candidate
  function automatic void predict(input logic [63:0] a, input logic [7:0] d);
    logic [57:0] base, blk, sd;
    base = a[63:6];
    sd   = {{50{d[7]}}, d};
    blk  = base;
    expN = 0;
    for (int i = 0; i < DEG; i++) begin
      if (blk[57:6] != base[57:6]) break;
      if (!mHas(blk)) begin
        expBlk[expN] = blk;
        expN++;
        mPush(blk);
      end
      blk = blk + sd;
    end
  endfunction

  task automatic hitPush(input logic [63:0] a);
    @(negedge clk);
    hitValid = 1'b1;
    hitAddr  = a;
    @(negedge clk);
    hitValid = 1'b0;
    mPush(a[63:6]);
  endtask

  task automatic runCand(input logic [63:0] a, input logic [7:0] d, input bit mf,
                         input int stallPct, input string tag, output int got);
    bit rdy;
    predict(a, d);
    got = 0;
    @(negedge clk);
    mshrFull  = mf;
    candValid = 1'b1;
    candAddr  = a;
    candDelta = d;
    #1;
    while (!candReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    candValid = 1'b0;
    for (int k = 0; k < 80; k++) begin
      rdy = ($urandom_range(99) >= stallPct);
      reqReady = rdy;
      #1;
      if (!reqValid && candReady) break;
      if (reqValid && !rdy)
        chk(candReady == 1'b0, "R2", "candReady during stall", {63'd0, candReady}, 64'd0);
      if (reqValid && rdy) begin
        if (got < expN) begin
          chk(reqAddr == {expBlk[got], 6'd0}, tag, "R3 request address", reqAddr,
              {expBlk[got], 6'd0});
          chk(reqFillLlc == mf, "R9", "fill level", {63'd0, reqFillLlc}, {63'd0, mf});
        end else begin
          chk(1'b0, tag, "extra request", reqAddr, 64'd0);
        end
        got++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk(got == expN, tag, "request count", 64'(got), 64'(expN));
  endtask

  initial begin
    int n;
    logic [63:0] ya;
    for (int i = 0; i < HD; i++) mVld[i] = 0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(reqValid == 1'b0, "R1", "reqValid after reset", {63'd0, reqValid}, 64'd0);
    chk(candReady == 1'b1, "R1", "candReady after reset", {63'd0, candReady}, 64'd1);

    // R3 expansion: block 5, step 2 -> blocks 5,7,9 (R1: none suppressed)
    runCand(64'h0000_1000_0000_0140, 8'd2, 1'b0, 0, "R3", n);
    chk(n == 3, "R3", "three-step expansion", 64'(n), 64'd3);
    // R4 R5 same candidate again: all already issued
    runCand(64'h0000_1000_0000_0140, 8'd2, 1'b0, 0, "R4", n);
    chk(n == 0, "R4", "repeat suppressed", 64'(n), 64'd0);
    // R5 zero step: only the first address issues, later steps see it
    runCand(64'h0000_1000_0000_0800, 8'd0, 1'b0, 0, "R5", n);
    chk(n == 1, "R5", "self duplicate", 64'(n), 64'd1);
    // R8 page crossing upward (blocks 62,63 then cross) and downward
    runCand(64'h0000_2000_0000_0F80, 8'd1, 1'b0, 0, "R8", n);
    chk(n == 2, "R8", "upward cross stops", 64'(n), 64'd2);
    runCand(64'h0000_2000_0000_3040, 8'hFF, 1'b0, 0, "R8", n);
    chk(n == 2, "R8", "downward cross stops", 64'(n), 64'd2);
    // R9 last-level fill
    runCand(64'h0000_3000_0000_0000, 8'd3, 1'b1, 0, "R9", n);
    chk(n == 3, "R9", "llc requests", 64'(n), 64'd3);
    // R6 recorded hit suppresses the first step only
    hitPush(64'h0000_4000_0000_0200);
    runCand(64'h0000_4000_0000_0210, 8'd5, 1'b0, 0, "R6", n);
    chk(n == 2, "R6", "hit-recorded block skipped", 64'(n), 64'd2);
    // R7 eviction after DEPTH newer writes
    ya = 64'h0000_5000_0000_0400;
    hitPush(ya);
    for (int i = 0; i < HD - 1; i++) hitPush(64'h0000_6000_0000_0000 + 64'(i) * 64'h1000);
    runCand(ya, 8'd0, 1'b0, 0, "R7", n);
    chk(n == 0, "R7", "still held", 64'(n), 64'd0);
    hitPush(64'h0000_7000_0000_0000);
    runCand(ya, 8'd0, 1'b0, 0, "R7", n);
    chk(n == 1, "R7", "oldest overwritten", 64'(n), 64'd1);
    // R10 heavy back-pressure
    runCand(64'h0000_8000_0000_0000, 8'd1, 1'b0, 85, "R10", n);
    chk(n == 3, "R10", "all delivered under stall", 64'(n), 64'd3);

    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [63:0] a;
      logic [7:0]  d;
      a = {20'h0, 32'(20'h90000 + $urandom_range(3)), 6'($urandom_range(63)), 6'h0};
      d = 8'($signed($urandom_range(8)) - 4);
      if ($urandom_range(3) == 0) hitPush(a + 64'($urandom_range(3)) * 64'h40);
      runCand(a, d, 1'($urandom_range(1)), 30, "R4/R8", n);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule